// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This block decides which of several hardware threads owns a single-issue pipeline. Each thread keeps its own saved program counter and a ready flag. The running thread issues every cycle and no other thread interferes. Ownership changes only when the pipeline reports a long-latency stall, such as a second-level cache miss. Short stalls are left to the pipeline and never cause a switch.

On a long stall the block does four things. It stores the faulting PC as the restart point of the old thread. It marks that thread as waiting. It raises a one-cycle flush that empties the pipeline. In the next cycle it redirects fetch to the saved PC of the next ready thread, chosen round-robin. The new thread then refills the pipeline, and for a fixed number of cycles equal to the pipeline depth nothing completes. If every thread is waiting, fetch is held stalled until a miss-done report makes a thread ready again.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, thread 0 is active and all threads are ready. `redir_valid_o` is high, with `redir_pc_o` equal to thread 0's reset vector. The reset vector of thread t is RST_BASE + t*RST_STRIDE.
- R2: When `long_stall_i` is sampled high while `fetch_stall_o` is low, `flush_o` is high in the next cycle, for exactly one cycle. `fetch_stall_o` is high and `redir_valid_o` is low in that cycle.
- R3: `short_stall_i` has no effect. Without a sampled `long_stall_i`, `flush_o` stays low and `active_tid_o` does not change.
- R4: When a switched-out thread is later chosen again, `redir_pc_o` equals the `stall_pc_i` value that was sampled with the stall that switched it out.
- R5: In the cycle after the flush, the next thread is picked from the ready threads by searching active+1, active+2, and so on, modulo the thread count, with the current thread searched last. `active_tid_o` takes the new thread's ID, and `redir_valid_o` pulses for one cycle. `active_tid_o` changes only in a cycle with `redir_valid_o` high.
- R6: A thread's ready flag is cleared when it is switched out. It is set again when `miss_done_i` is sampled high with `miss_tid_i` equal to that thread's ID. If a clear and a set for the same thread are sampled in the same cycle, the clear wins. A miss-done report for a thread that is already ready has no effect.
- R7: If no thread is ready after a flush, `fetch_stall_o` stays high and no redirect occurs. When a miss-done report is sampled, the redirect follows in the next cycle.
- R8: `refill_o` is high for exactly DEPTH cycles, starting in the redirect cycle. `fetch_stall_o` is low throughout.
- R9: `long_stall_i` is ignored while `fetch_stall_o` is high, that is, during a flush or an idle period.
- R10: A thread that has never been switched out is resumed at its reset vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| long_stall_i | input | 1 | Long-latency stall of the active thread |
| stall_pc_i | input | PC_W | PC of the stalled instruction |
| short_stall_i | input | 1 | Short stall from the pipeline (ignored) |
| miss_done_i | input | 1 | A long miss has been serviced |
| miss_tid_i | input | TID_W | Thread whose miss was serviced |
| active_tid_o | output | TID_W | Thread owning the pipeline |
| redir_valid_o | output | 1 | Fetch redirect strobe |
| redir_pc_o | output | PC_W | Fetch redirect target |
| flush_o | output | 1 | One-cycle flush of in-flight instructions |
| fetch_stall_o | output | 1 | Fetch held off |
| refill_o | output | 1 | Refill window, no instruction completes |

## Verification
The bench targets several corner cases, each tied to a specific fault:
- All four threads are stalled in turn, leaving nobody ready. A design that still picks the current thread would redirect into a thread that is still waiting.
- Long stalls are sent during the flush and idle cycles. A design that honours them would emit a second flush and corrupt a saved PC.
- A miss-done report goes to a thread that is already running. It must leave ownership unchanged.
- Wrap-around in the round-robin search is checked. An off-by-one start point shows up as the wrong `active_tid_o`.
- Threads that have never run are resumed. A design that forgot the reset vectors would redirect to a stale or zero PC.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_REFILL = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_IDLE   = 2'd3
    } cgmt_state_e;
endpackage

// File: rtl/cgmt_rr_pick.sv
// Round-robin search over ready threads, starting after the current one.
module cgmt_rr_pick #(
    parameter int NTHR  = 4,
    parameter int TID_W = 2
) (
    input  logic [NTHR-1:0]  ready_i,
    input  logic [TID_W-1:0] cur_i,
    output logic             found_o,
    output logic [TID_W-1:0] tid_o
);
    always_comb begin
        found_o = 1'b0;
        tid_o   = cur_i;
        for (int off = 1; off <= NTHR; off++) begin
            int idx;
            idx = (int'(cur_i) + off) % NTHR;
            if (!found_o && ready_i[idx]) begin
                found_o = 1'b1;
                tid_o   = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/cgmt_pc_bank.sv
// One restart PC per thread, each reset to its own vector.
module cgmt_pc_bank #(
    parameter int          NTHR       = 4,
    parameter int          TID_W      = 2,
    parameter int          PC_W       = 32,
    parameter logic [31:0] RST_BASE   = 32'h0000_1000,
    parameter logic [31:0] RST_STRIDE = 32'h0000_0100
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [TID_W-1:0] wr_tid_i,
    input  logic [PC_W-1:0]  wr_pc_i,
    input  logic [TID_W-1:0] rd_tid_i,
    output logic [PC_W-1:0]  rd_pc_o
);
    logic [PC_W-1:0] pc_q [NTHR];

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        localparam logic [PC_W-1:0] VEC = PC_W'(RST_BASE + RST_STRIDE * t);
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pc_q[t] <= VEC;
            end else if (wr_en_i && (int'(wr_tid_i) == t)) begin
                pc_q[t] <= wr_pc_i;
            end
        end
    end

    assign rd_pc_o = pc_q[rd_tid_i];
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
    parameter int          NTHR       = 4,
    parameter int          PC_W       = 32,
    parameter int          DEPTH      = 5,
    parameter logic [31:0] RST_BASE   = 32'h0000_1000,
    parameter logic [31:0] RST_STRIDE = 32'h0000_0100,
    localparam int         TID_W      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             long_stall_i,
    input  logic [PC_W-1:0]  stall_pc_i,
    input  logic             short_stall_i,
    input  logic             miss_done_i,
    input  logic [TID_W-1:0] miss_tid_i,
    output logic [TID_W-1:0] active_tid_o,
    output logic             redir_valid_o,
    output logic [PC_W-1:0]  redir_pc_o,
    output logic             flush_o,
    output logic             fetch_stall_o,
    output logic             refill_o
);
    import cgmt_pkg::*;

    localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH + 1) : 1;

    typedef struct packed {
        cgmt_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [TID_W-1:0] act;
        logic [NTHR-1:0]  rdy;
        logic             redir;
        logic [PC_W-1:0]  rpc;
    } ctrl_s;

    ctrl_s q, d;

    logic [NTHR-1:0]  done_mask;
    logic [NTHR-1:0]  rdy_set;
    logic             pick_ok;
    logic [TID_W-1:0] pick_tid;
    logic [PC_W-1:0]  pick_pc;
    logic             pc_wr;
    logic             unused_short;

    assign unused_short = short_stall_i;

    cgmt_rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) u_pick (
        .ready_i (rdy_set),
        .cur_i   (q.act),
        .found_o (pick_ok),
        .tid_o   (pick_tid)
    );

    cgmt_pc_bank #(
        .NTHR(NTHR), .TID_W(TID_W), .PC_W(PC_W),
        .RST_BASE(RST_BASE), .RST_STRIDE(RST_STRIDE)
    ) u_pcs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (pc_wr),
        .wr_tid_i (q.act),
        .wr_pc_i  (stall_pc_i),
        .rd_tid_i (pick_tid),
        .rd_pc_o  (pick_pc)
    );

    always_comb begin
        done_mask = '0;
        if (miss_done_i) begin
            done_mask[miss_tid_i] = 1'b1;
        end
        rdy_set = q.rdy | done_mask;

        d       = q;
        d.redir = 1'b0;
        d.rdy   = rdy_set;
        pc_wr   = 1'b0;

        unique case (q.st)
            ST_RUN, ST_REFILL: begin
                if (long_stall_i) begin
                    d.st         = ST_FLUSH;
                    d.rdy[q.act] = 1'b0;
                    pc_wr        = 1'b1;
                end else if (q.st == ST_REFILL) begin
                    if (q.cnt == '0) begin
                        d.st = ST_RUN;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            default: begin
                if (pick_ok) begin
                    d.st    = ST_REFILL;
                    d.cnt   = CNT_W'(DEPTH - 1);
                    d.act   = pick_tid;
                    d.redir = 1'b1;
                    d.rpc   = pick_pc;
                end else begin
                    d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st    <= ST_REFILL;
            q.cnt   <= CNT_W'(DEPTH - 1);
            q.act   <= '0;
            q.rdy   <= '1;
            q.redir <= 1'b1;
            q.rpc   <= PC_W'(RST_BASE);
        end else begin
            q <= d;
        end
    end

    assign active_tid_o  = q.act;
    assign redir_valid_o = q.redir;
    assign redir_pc_o    = q.rpc;
    assign flush_o       = (q.st == ST_FLUSH);
    assign fetch_stall_o = (q.st == ST_FLUSH) || (q.st == ST_IDLE);
    assign refill_o      = (q.st == ST_REFILL);
endmodule

// File: rtl/cgmt_switch_ctrl_chk.sv
module cgmt_switch_ctrl_chk #(
    parameter int TID_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             long_stall_i,
    input logic [TID_W-1:0] active_tid_o,
    input logic             redir_valid_o,
    input logic             flush_o,
    input logic             fetch_stall_o,
    input logic             refill_o
);
    AST_FLUSH_ON_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (long_stall_i && !fetch_stall_o) |=> flush_o); // R2
    AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> !flush_o); // R2
    AST_FLUSH_HOLDS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> (fetch_stall_o && !redir_valid_o)); // R2
    AST_NO_SWITCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !long_stall_i |=> !flush_o); // R3
    AST_OWNER_CHANGES_ON_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !redir_valid_o |-> $stable(active_tid_o)); // R5
    AST_REDIR_STARTS_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redir_valid_o |-> (refill_o && !fetch_stall_o)); // R8
    AST_STALLED_IGNORES_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_stall_o |=> !flush_o); // R9
endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(.TID_W(TID_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .long_stall_i  (long_stall_i),
    .active_tid_o  (active_tid_o),
    .redir_valid_o (redir_valid_o),
    .flush_o       (flush_o),
    .fetch_stall_o (fetch_stall_o),
    .refill_o      (refill_o)
);

// File: tb/cgmt_switch_ctrl_test.sv
module cgmt_switch_ctrl_test;
    localparam int          NT     = 4;
    localparam int          DEPTH  = 5;
    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [31:0] STRIDE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_stall = 1'b0;
    logic [31:0] stall_pc = '0;
    logic        short_stall = 1'b0;
    logic        miss_done = 1'b0;
    logic [1:0]  miss_tid = '0;
    logic [1:0]  active_tid;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic        flush;
    logic        fetch_stall;
    logic        refill;

    always #5 clk = ~clk;

    cgmt_switch_ctrl #(.NTHR(NT), .PC_W(32), .DEPTH(DEPTH),
                       .RST_BASE(BASE), .RST_STRIDE(STRIDE)) uut (
        .clk_i(clk), .rst_ni(rst_n), .long_stall_i(long_stall), .stall_pc_i(stall_pc),
        .short_stall_i(short_stall), .miss_done_i(miss_done), .miss_tid_i(miss_tid),
        .active_tid_o(active_tid), .redir_valid_o(redir_valid), .redir_pc_o(redir_pc),
        .flush_o(flush), .fetch_stall_o(fetch_stall), .refill_o(refill)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model: 0 run, 1 refill, 2 flush, 3 idle
    int          m_st, m_cnt, m_act;
    logic [3:0]  m_rdy;
    logic [31:0] m_pcs [4];
    logic        m_redir;
    logic [31:0] m_rpc;
    bit          m_first;
    bit          m_prev_ls, m_prev_fs;

    function automatic logic [31:0] vec(int t);
        return BASE + STRIDE * t;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 1; m_cnt = DEPTH - 1; m_act = 0; m_rdy = 4'hF;
            for (int t = 0; t < NT; t++) m_pcs[t] = vec(t);
            m_redir = 1'b1; m_rpc = vec(0); m_first = 1'b1;
            m_prev_ls = 1'b0; m_prev_fs = 1'b0;
        end else begin
            logic [3:0] rs;
            bit         fnd;
            m_prev_ls = long_stall;
            m_prev_fs = (m_st >= 2);
            m_first   = 1'b0;
            rs = m_rdy;
            if (miss_done) rs[miss_tid] = 1'b1;
            m_redir = 1'b0;
            if (m_st <= 1) begin
                if (long_stall) begin
                    m_pcs[m_act] = stall_pc;
                    rs[m_act] = 1'b0;
                    m_st = 2;
                end else if (m_st == 1) begin
                    if (m_cnt == 0) m_st = 0;
                    else m_cnt = m_cnt - 1;
                end
            end else begin
                fnd = 1'b0;
                for (int k = 1; k <= NT; k++) begin
                    int c;
                    c = (m_act + k) % NT;
                    if (!fnd && rs[c]) begin
                        fnd = 1'b1;
                        m_act = c;
                    end
                end
                if (fnd) begin
                    m_redir = 1'b1; m_rpc = m_pcs[m_act];
                    m_st = 1; m_cnt = DEPTH - 1;
                end else begin
                    m_st = 3;
                end
            end
            m_rdy = rs;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        string tf;
        tf = m_first ? "R1 flush" : (m_prev_fs ? "R9 flush" : (m_prev_ls ? "R2 flush" : "R3 flush"));
        chk(m_first ? "R1 active" : "R5 R6 active", 32'(active_tid), 32'(m_act));
        chk(tf, 32'(flush), 32'(m_st == 2));
        chk("R7 fetch_stall", 32'(fetch_stall), 32'(m_st >= 2));
        chk("R8 refill", 32'(refill), 32'(m_st == 1));
        chk(m_first ? "R1 redir_valid" : "R5 redir_valid", 32'(redir_valid), 32'(m_redir));
        if (m_redir) chk("R4 R10 redir_pc", redir_pc, m_rpc);
    endtask

    task automatic step(bit rs, bit ls, logic [31:0] pc, bit ss, bit md, logic [1:0] mt);
        @(negedge clk);
        compare_all();
        rst_n = rs; long_stall = ls; stall_pc = pc; short_stall = ss;
        miss_done = md; miss_tid = mt;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1, 0, 32'h0, i[0], 0, 2'd0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
        // R1 reset state visible at the release edge
        step(1, 0, 0, 0, 0, 0);
        // R3 short stalls only
        for (int i = 0; i < 10; i++) step(1, 0, 32'hDEAD_0000, 1, 0, 0);
        // R2 R10 thread 0 switches out, thread 1 resumes at its vector
        step(1, 1, 32'h0000_2000, 0, 0, 0);
        step(1, 1, 32'h0000_2222, 0, 0, 0); // R9 second stall during flush
        idle(8);
        step(1, 1, 32'h0000_3000, 0, 0, 0);
        idle(8);
        step(1, 1, 32'h0000_4000, 0, 0, 0);
        idle(8);
        step(1, 1, 32'h0000_5000, 0, 0, 0);
        // R7 nobody ready; R9 stalls while idle are ignored
        for (int i = 0; i < 6; i++) step(1, i[0], 32'h0000_6000, 0, 0, 0);
        // R4 R6 thread 2 returns with its saved PC
        step(1, 0, 0, 0, 1, 2'd2);
        idle(3);
        step(1, 0, 0, 0, 1, 2'd2); // R6 report for a ready thread
        step(1, 0, 0, 0, 1, 2'd0);
        idle(8);
        // R5 wrap-around: from 2, thread 3 waits, thread 0 chosen
        step(1, 1, 32'h0000_4400, 0, 0, 0);
        idle(8);
        // clear and set of the same thread in one cycle (R6)
        step(1, 1, 32'h0000_7000, 0, 1, 2'd0);
        idle(10);
        for (int i = 0; i < 3000; i++) begin
            step(1, ($urandom % 9) == 0, $urandom & 32'hFFFF_FFFC, ($urandom % 3) == 0,
                 ($urandom % 6) == 0, 2'($urandom % 4));
        end
        idle(4);
        summary();
        $finish;
    end
endmodule